// File: doc/BRIEF.md
# Sparse Activation Scan and Broadcast Unit

This unit sits at the centre of an array of processing elements that multiply a sparse input activation vector by a weight matrix. It holds the source activation vector in a local store and keeps one "still to send" flag per element. In compute mode it finds, every cycle, the lowest-indexed element that is non-zero and not yet sent. It presents that element's value and index to all processing elements at once, then clears its flag. Zero elements are never sent. The search runs through a tree of four-input detection nodes. Each node passes up the first of its children that holds a non-zero, together with that child's position.

In load mode the processing elements are told to stay idle, no broadcast happens, and the activation store is written through a simple load port. Each processing element raises a per-element "queue full" line. A single full queue anywhere freezes the global broadcast for that cycle. When every non-zero has gone out, a done flag rises and stays up for as long as compute mode is held. To start a new round, the unit is returned to load mode and the vector is loaded again.

Top module: `sparse_act_bcast`

## Requirements
- R1: While reset is high and in the cycle after it, `bcast_valid` and `done` are 0, `pe_idle` is 1, and no element is flagged as pending.
- R2: With `compute_mode` = 0, a `ld_we` pulse stores `ld_data` at `ld_addr`. Writing a non-zero value marks that element pending, and writing zero clears its pending mark.
- R3: With `compute_mode` = 1, `ld_we` has no effect on the store or on the pending marks.
- R4: In compute mode each pending element is broadcast exactly once. `bcast_index` carries its position and `bcast_value` carries the value stored there, and elements go out in strictly ascending index order within a round.
- R5: A broadcast is issued from a clock cycle in which `compute_mode` = 1, no `pe_full` bit is set and some element is pending. `bcast_valid` is high in the following cycle, and at most one element goes out per cycle.
- R6: If any bit of `pe_full` is 1 in a cycle, `bcast_valid` is 0 in the next cycle.
- R7: One cycle after `compute_mode` is 0, `bcast_valid` is 0 and `pe_idle` is 1. One cycle after `compute_mode` is 1, `pe_idle` is 0.
- R8: `done` is 1 exactly in the cycles that follow a cycle in which `compute_mode` = 1 and no element is pending. `done` and `bcast_valid` are never high together.
- R9: A vector loaded with only zeros raises `done` one cycle after compute mode begins, with no broadcast.
- R10: Leaving compute mode in the middle of a round pauses it. Pending marks are kept, and on return the round resumes from the next pending element.
- R11: Priority crosses subtree boundaries: index 0 and the last index (VEC_LEN-1) are found, and neighbours that sit in different four-input groups (for example 15 and 16) are sent in ascending order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| compute_mode | input | 1 | 1 = compute (broadcast), 0 = load mode (PEs idle) |
| ld_we | input | 1 | Load port write enable, honoured in load mode only |
| ld_addr | input | IDX_W | Load port element index |
| ld_data | input | VAL_W | Load port activation value |
| pe_full | input | NUM_PE | One queue-full line per processing element |
| bcast_valid | output | 1 | A broadcast element is present this cycle |
| bcast_value | output | VAL_W | Activation value being broadcast |
| bcast_index | output | IDX_W | Column index of the broadcast element |
| pe_idle | output | 1 | Holds the processing elements idle |
| done | output | 1 | No pending element remains in compute mode |

## Verification
The bound checker looks at every cycle for these properties:
- a full queue blocks the next broadcast;
- load mode silences the broadcast and raises the idle line;
- done never coincides with a broadcast, nor with idle;
- indices within a round strictly increase.

Whether the right values leave, whether each non-zero leaves exactly once, and whether zero writes really clear an element can only be shown by the bench's scenarios. The same holds for loads being ignored in compute mode and for a paused round resuming correctly. In those scenarios a behavioural model predicts every output on every clock.

// File: rtl/sab_pkg.sv
package sab_pkg;

  // Number of four-way levels needed to reduce n leaves to one root.
  function automatic int tree_levels(input int n);
    int l;
    int m;
    l = 0;
    m = n;
    while (m > 1) begin
      m = m / 4;
      l++;
    end
    return l;
  endfunction

  // Offset of the first node of level k in a flattened level array.
  function automatic int level_base(input int n, input int k);
    int b;
    int m;
    b = 0;
    m = n;
    for (int j = 0; j < k; j++) begin
      b += m;
      m = m / 4;
    end
    return b;
  endfunction

endpackage

// File: rtl/lnzd_node.sv
module lnzd_node #(
  parameter int IDX_W = 6,
  parameter int SHIFT = 0
) (
  input  logic [3:0]            kid_v,
  input  logic [3:0][IDX_W-1:0] kid_idx,
  output logic                  any_v,
  output logic [IDX_W-1:0]      win_idx
);

  // Lowest-numbered child holding a non-zero wins; its slot number is
  // placed above the bits already resolved by the child.
  always_comb begin
    any_v   = |kid_v;
    win_idx = '0;
    for (int c = 3; c >= 0; c--) begin
      if (kid_v[c]) begin
        win_idx = (IDX_W'(c) << SHIFT) | kid_idx[c];
      end
    end
  end

endmodule

// File: rtl/lnzd_tree.sv
module lnzd_tree #(
  parameter int VEC_LEN = 64,
  parameter int IDX_W   = $clog2(VEC_LEN)
) (
  input  logic [VEC_LEN-1:0] pending,
  output logic               found,
  output logic [IDX_W-1:0]   first_idx
);

  localparam int LEVELS = sab_pkg::tree_levels(VEC_LEN);
  localparam int TOTAL  = sab_pkg::level_base(VEC_LEN, LEVELS) + 1;

  logic [TOTAL-1:0]            all_v;
  logic [TOTAL-1:0][IDX_W-1:0] all_i;

  assign all_v[VEC_LEN-1:0] = pending;
  assign all_i[VEC_LEN-1:0] = '0;

  for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
    localparam int NODES = VEC_LEN >> (2 * k);
    localparam int SRC   = sab_pkg::level_base(VEC_LEN, k - 1);
    localparam int DST   = sab_pkg::level_base(VEC_LEN, k);
    for (genvar n = 0; n < NODES; n++) begin : g_node
      lnzd_node #(
        .IDX_W (IDX_W),
        .SHIFT (2 * (k - 1))
      ) u_node (
        .kid_v   (all_v[SRC + 4*n +: 4]),
        .kid_idx (all_i[SRC + 4*n +: 4]),
        .any_v   (all_v[DST + n]),
        .win_idx (all_i[DST + n])
      );
    end
  end

  assign found     = all_v[TOTAL-1];
  assign first_idx = all_i[TOTAL-1];

endmodule

// File: rtl/act_store.sv
module act_store #(
  parameter int DEPTH  = 64,
  parameter int VAL_W  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [VAL_W-1:0]  rd_data
);

  logic [VAL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/sparse_act_bcast.sv
module sparse_act_bcast #(
  parameter int VEC_LEN = 64,
  parameter int VAL_W   = 16,
  parameter int NUM_PE  = 4,
  localparam int IDX_W  = $clog2(VEC_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              compute_mode,
  input  logic              ld_we,
  input  logic [IDX_W-1:0]  ld_addr,
  input  logic [VAL_W-1:0]  ld_data,
  input  logic [NUM_PE-1:0] pe_full,
  output logic              bcast_valid,
  output logic [VAL_W-1:0]  bcast_value,
  output logic [IDX_W-1:0]  bcast_index,
  output logic              pe_idle,
  output logic              done
);

  logic [VEC_LEN-1:0] pending;
  logic               sel_found;
  logic [IDX_W-1:0]   sel_idx;
  logic               fire;
  logic               load_ok;

  assign load_ok = ld_we & ~compute_mode;
  assign fire    = compute_mode & ~(|pe_full) & sel_found;

  lnzd_tree #(
    .VEC_LEN (VEC_LEN),
    .IDX_W   (IDX_W)
  ) u_tree (
    .pending   (pending),
    .found     (sel_found),
    .first_idx (sel_idx)
  );

  act_store #(
    .DEPTH  (VEC_LEN),
    .VAL_W  (VAL_W),
    .ADDR_W (IDX_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (load_ok),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_en   (fire),
    .rd_addr (sel_idx),
    .rd_data (bcast_value)
  );

  // Pending marks: set or cleared by loads, cleared when broadcast.
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
    end else if (load_ok) begin
      pending[ld_addr] <= (ld_data != '0);
    end else if (fire) begin
      pending[sel_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcast_valid <= 1'b0;
      bcast_index <= '0;
      pe_idle     <= 1'b1;
      done        <= 1'b0;
    end else begin
      bcast_valid <= fire;
      if (fire) begin
        bcast_index <= sel_idx;
      end
      pe_idle <= ~compute_mode;
      done    <= compute_mode & ~(|pending);
    end
  end

endmodule

// File: rtl/sparse_act_bcast_chk.sv
module sparse_act_bcast_chk #(
  parameter int IDX_W  = 6,
  parameter int NUM_PE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              compute_mode,
  input logic              ld_we,
  input logic [NUM_PE-1:0] pe_full,
  input logic              bcast_valid,
  input logic [IDX_W-1:0]  bcast_index,
  input logic              pe_idle,
  input logic              done
);

  logic             seen;
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      last_idx <= '0;
    end else if (ld_we && !compute_mode) begin
      seen <= 1'b0;
    end else if (bcast_valid) begin
      seen     <= 1'b1;
      last_idx <= bcast_index;
    end
  end

  // R6
  full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (|pe_full) |=> !bcast_valid);

  // R7
  load_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !compute_mode |=> (!bcast_valid && pe_idle));

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bcast_valid && !pe_idle));

  // R4
  ascending_chk: assert property (@(posedge clk) disable iff (rst)
    (bcast_valid && seen) |-> (bcast_index > last_idx));

  // R7
  compute_wakes_chk: assert property (@(posedge clk) disable iff (rst)
    compute_mode |=> !pe_idle);

endmodule

bind sparse_act_bcast sparse_act_bcast_chk #(
  .IDX_W  (IDX_W),
  .NUM_PE (NUM_PE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .compute_mode (compute_mode),
  .ld_we        (ld_we),
  .pe_full      (pe_full),
  .bcast_valid  (bcast_valid),
  .bcast_index  (bcast_index),
  .pe_idle      (pe_idle),
  .done         (done)
);

// File: tb/tb_sparse_act_bcast.sv
module tb_sparse_act_bcast;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_LEN    = 64;
  localparam int VAL_W      = 16;
  localparam int NUM_PE     = 4;
  localparam int IDX_W      = $clog2(VEC_LEN);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              compute_mode = 1'b0;
  logic              ld_we = 1'b0;
  logic [IDX_W-1:0]  ld_addr = '0;
  logic [VAL_W-1:0]  ld_data = '0;
  logic [NUM_PE-1:0] pe_full = '0;
  logic              bcast_valid;
  logic [VAL_W-1:0]  bcast_value;
  logic [IDX_W-1:0]  bcast_index;
  logic              pe_idle;
  logic              done;

  sparse_act_bcast #(
    .VEC_LEN (VEC_LEN),
    .VAL_W   (VAL_W),
    .NUM_PE  (NUM_PE)
  ) dut (
    .clk (clk), .rst (rst), .compute_mode (compute_mode),
    .ld_we (ld_we), .ld_addr (ld_addr), .ld_data (ld_data),
    .pe_full (pe_full), .bcast_valid (bcast_valid),
    .bcast_value (bcast_value), .bcast_index (bcast_index),
    .pe_idle (pe_idle), .done (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  int    bc_count = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // Behavioural reference model
  int m_mem [VEC_LEN];
  bit m_pend [VEC_LEN];
  bit e_valid = 0;
  int e_idx = 0;
  int e_val = 0;
  bit e_idle = 1;
  bit e_done = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      e_valid = 0; e_idle = 1; e_done = 0;
    end else begin
      int first;
      first = -1;
      for (int i = 0; i < VEC_LEN; i++) if (m_pend[i] && first < 0) first = i;
      e_done = compute_mode && (first < 0);
      e_idle = !compute_mode;
      if (compute_mode && pe_full == '0 && first >= 0) begin
        e_valid = 1; e_idx = first; e_val = m_mem[first]; m_pend[first] = 0;
      end else begin
        e_valid = 0;
      end
      if (!compute_mode && ld_we) begin
        m_mem[ld_addr]  = int'(ld_data);
        m_pend[ld_addr] = (ld_data != 0);
      end
    end
  end

  task automatic check(input string req, input bit ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(cur_req, bcast_valid == e_valid, "valid", int'(bcast_valid), int'(e_valid));
      if (e_valid && bcast_valid) begin
        check(cur_req, int'(bcast_index) == e_idx, "index", int'(bcast_index), e_idx);
        check(cur_req, int'(bcast_value) == e_val, "value", int'(bcast_value), e_val);
      end
      check(cur_req, pe_idle == e_idle, "pe_idle", int'(pe_idle), int'(e_idle));
      check(cur_req, done == e_done, "done", int'(done), int'(e_done));
      if (bcast_valid) bc_count++;
    end
  end

  task automatic load(input int a, input int v);
    @(negedge clk);
    ld_we = 1; ld_addr = IDX_W'(a); ld_data = VAL_W'(v);
    @(negedge clk);
    ld_we = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < VEC_LEN; i++) load(i, 0);
  endtask

  task automatic run_to_done();
    @(negedge clk);
    compute_mode = 1;
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
  endtask

  task automatic to_load_mode();
    @(negedge clk);
    compute_mode = 0;
    pe_full = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", bcast_valid == 0 && done == 0 && pe_idle == 1, "reset outputs",
          int'({bcast_valid, done, pe_idle}), 1);
    rst = 0;
    @(negedge clk);
    check("R1", bcast_valid == 0 && done == 0 && pe_idle == 1, "post-reset outputs",
          int'({bcast_valid, done, pe_idle}), 1);

    // R9: all-zero vector
    cur_req = "R9";
    clear_all();
    base = bc_count;
    @(negedge clk);
    compute_mode = 1;
    @(negedge clk);
    check("R9", done == 1, "done after one cycle", int'(done), 1);
    repeat (3) @(negedge clk);
    check("R9", bc_count == base, "broadcast count", bc_count - base, 0);
    to_load_mode();

    // R2 / R4 / R11: sparse pattern across subtree boundaries
    cur_req = "R11";
    load(0, 11); load(15, 22); load(16, 33); load(40, 44); load(63, 55);
    load(7, 5); load(7, 0);  // R2 zero write clears the mark
    base = bc_count;
    run_to_done();
    check("R4", bc_count - base == 5, "sparse broadcast count", bc_count - base, 5);
    check("R8", done == 1, "done at end", int'(done), 1);

    // R3: loads ignored in compute mode
    cur_req = "R3";
    base = bc_count;
    @(negedge clk);
    ld_we = 1; ld_addr = 6'd5; ld_data = 16'd9;
    @(negedge clk);
    ld_we = 0;
    repeat (3) @(negedge clk);
    check("R3", done == 1 && bc_count == base, "load in compute", bc_count - base, 0);
    to_load_mode();
    run_to_done();
    check("R3", bc_count == base, "nothing pending after rerun", bc_count - base, 0);
    to_load_mode();

    // R6 / R5: full queue holds the broadcast
    cur_req = "R6";
    for (int i = 0; i < 8; i++) load(i * 7 + 1, 100 + i);
    base = bc_count;
    @(negedge clk);
    pe_full = 4'b0100;
    compute_mode = 1;
    repeat (5) @(negedge clk);
    check("R6", bc_count == base, "held by full", bc_count - base, 0);
    cur_req = "R5";
    for (int i = 0; i < 40; i++) begin
      pe_full = (i % 3 == 0) ? 4'b0001 : 4'b0000;
      @(negedge clk);
    end
    pe_full = '0;
    run_to_done();
    check("R5", bc_count - base == 8, "count under stalls", bc_count - base, 8);
    to_load_mode();

    // R10 / R7: pause mid-round
    cur_req = "R10";
    for (int i = 0; i < 6; i++) load(i * 10 + 2, 200 + i);
    base = bc_count;
    @(negedge clk);
    compute_mode = 1;
    repeat (3) @(negedge clk);
    compute_mode = 0;
    repeat (2) @(negedge clk);
    begin
      int paused;
      paused = bc_count;
      repeat (3) @(negedge clk);
      check("R7", pe_idle == 1 && bc_count == paused, "quiet in load mode",
            bc_count - paused, 0);
    end
    run_to_done();
    check("R10", bc_count - base == 6, "resumed count", bc_count - base, 6);
    to_load_mode();

    // R4: dense vector under random stalls
    cur_req = "R4";
    for (int i = 0; i < VEC_LEN; i++) load(i, i + 1);
    base = bc_count;
    @(negedge clk);
    compute_mode = 1;
    for (int i = 0; i < 300 && !done; i++) begin
      pe_full = NUM_PE'($urandom_range(0, 15) < 4 ? $urandom_range(1, 15) : 0);
      @(negedge clk);
    end
    pe_full = '0;
    run_to_done();
    check("R4", bc_count - base == VEC_LEN, "dense count", bc_count - base, VEC_LEN);
    to_load_mode();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule